// File: doc/BRIEF.md
# Banked Cartridge Mapper with Latched Real-Time Clock

This block sits between an 8-bit CPU bus and the ROM and RAM of a game cartridge. It decodes byte writes into the lower 32 KiB of the CPU address space as control writes. Four regions of 8 KiB each hold one control function:

| Region | Function |
|---|---|
| 0x0000-0x1FFF | enable for the external window |
| 0x2000-0x3FFF | switchable ROM bank |
| 0x4000-0x5FFF | window selector |
| 0x6000-0x7FFF | snapshot trigger |

From these registers the block forms a 21-bit ROM address and a 15-bit RAM address, together with the chip selects. The window at 0xA000-0xBFFF maps either to one of four RAM banks or to one of five clock registers.

The block keeps a running time of day. Seconds, minutes, hours and a 9-bit day count advance on a one-second strobe input. Software never reads these running counters directly. A two-write arming sequence copies them into a set of latched registers, and software reads those. The arming is held in a two-state machine:

- `LT_IDLE` moves to `LT_ARMED` on a write of 0x00 to the snapshot region (transition *arm*).
- `LT_ARMED` returns to `LT_IDLE` on any other write to that region. On a write of 0x01 the return also fires the snapshot (transition *fire*). On any other value the return only drops the arming (transition *disarm*).
- `LT_ARMED` stays in `LT_ARMED` on a repeated 0x00 (transition *rearm*).

Top module: `rtc_bank_mapper`

## Requirements
- R1: After reset the ROM bank is 1, the window is disabled, the selector is 0x00 and the snapshot machine is in `LT_IDLE`. All clock counters, halt and carry are 0.
- R2: A write of exactly 0x0A in 0x0000-0x1FFF enables the window, and any other byte there disables it. While the window is disabled, reads in 0xA000-0xBFFF give `map_rdata` = 0xFF, `ram_cs` stays low, and writes there change no clock register.
- R3: A write in 0x2000-0x3FFF sets the ROM bank to data bits 6:0, and a result of 0 becomes bank 1 (0xC5 gives 0x45, 0x80 gives 1). `rom_cs` is high for addresses below 0x8000. `rom_addr` is {7'b0, addr[13:0]} for 0x0000-0x3FFF and {bank, addr[13:0]} for 0x4000-0x7FFF.
- R4: A write of 0x00-0x03 in 0x4000-0x5FFF selects that RAM bank. Then, while enabled, an access in 0xA000-0xBFFF raises `ram_cs` with `ram_addr` = {bank[1:0], addr[12:0]}, and `map_rdata` is 0xFF.
- R5: A selector value of 0x08-0x0C maps a clock register into the window instead of RAM, so `ram_cs` stays low. Any other selector value maps nothing: reads give 0xFF and writes are ignored.
- R6: The clock register encoding is as follows. 0x08 is seconds in bits 5:0, 0x09 is minutes in bits 5:0, 0x0A is hours in bits 4:0, and 0x0B is day bits 7:0. 0x0C holds day bit 8 in bit 0, halt in bit 6 and carry in bit 7. Unused bits read 0.
- R7: A write of 0x01 to 0x6000-0x7FFF, when the previous write to that region was 0x00, copies the running counters into the latched registers at that clock edge. Reads always return the latched registers, so ticks alone do not change what is read.
- R8: A write to 0x6000-0x7FFF of any value other than 0x00 or 0x01 disarms the sequence, so a following 0x01 does not snapshot.
- R9: On each tick with halt clear, seconds advance. A field at or above its top value (59, 59, 23) wraps to 0 and carries into the next field. While halt is set, ticks change nothing.
- R10: A day count of 511 wraps to 0 on carry-in and sets the carry flag. The flag stays set until software writes register 0x0C.
- R11: A CPU write to a selected clock register sets the running and the latched field together, masked to the field width (0xD7 to hours reads 0x17).
- R12: When a CPU clock-register write and a tick fall in the same cycle, the write is applied and that tick is dropped for all fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle strobe once per second |
| cpu_wr | input | 1 | Write strobe, one cycle per write |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| rom_cs | output | 1 | ROM select (address below 0x8000) |
| rom_addr | output | 21 | Physical ROM byte address |
| ram_cs | output | 1 | External RAM select |
| ram_addr | output | 15 | Physical RAM byte address |
| map_rdata | output | 8 | Data the mapper returns in the window (0xFF when not driving) |

## Verification
The assertions assume that `cpu_wr` and `tick_1hz` are single-cycle strobes sampled at the rising edge. They also assume that the address and data are stable during a write cycle, and that clock fields are only loaded with in-range values when checking wrap points. The stimulus changes every input on the falling edge and drops each strobe after one edge. It writes only in-range times, except where the masking rule itself is under test. Collisions between a write and a tick are produced deliberately, and only for the case the same-cycle rule defines.

// File: rtl/rtcmap_pkg.sv
package rtcmap_pkg;

    typedef enum logic {
        LT_IDLE  = 1'b0,
        LT_ARMED = 1'b1
    } latch_st_e;

    localparam logic [7:0] SEL_RTC_LO  = 8'h08;
    localparam logic [7:0] SEL_RTC_HI  = 8'h0C;
    localparam logic [7:0] ENABLE_CODE = 8'h0A;

    localparam logic [5:0] SEC_TOP  = 6'd59;
    localparam logic [5:0] MIN_TOP  = 6'd59;
    localparam logic [4:0] HR_TOP   = 5'd23;
    localparam logic [8:0] DAY_TOP  = 9'd511;

    typedef struct packed {
        logic [5:0] sec;
        logic [5:0] min;
        logic [4:0] hr;
        logic [8:0] day;
        logic       halt;
        logic       carry;
    } rtc_time_t;

endpackage

// File: rtl/rtcmap_ctrl.sv
module rtcmap_ctrl
    import rtcmap_pkg::*;
#(
    parameter int ROM_BANK_W = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr,
    input  logic [2:0]            region,
    input  logic [7:0]            wdata,
    output logic                  win_en,
    output logic [ROM_BANK_W-1:0] rom_bank,
    output logic [7:0]            sel,
    output logic                  latch_fire
);
    localparam logic [ROM_BANK_W-1:0] BANK_ONE = ROM_BANK_W'(1);

    latch_st_e st_q, st_d;
    logic      trig_wr;

    assign trig_wr = wr && (region == 3'b011);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_en   <= 1'b0;
            rom_bank <= BANK_ONE;
            sel      <= 8'h00;
        end else if (wr) begin
            unique case (region)
                3'b000:  win_en <= (wdata == ENABLE_CODE);
                3'b001:  rom_bank <= (wdata[ROM_BANK_W-1:0] == '0) ? BANK_ONE
                                                                   : wdata[ROM_BANK_W-1:0];
                3'b010:  sel <= wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= LT_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d       = st_q;
        latch_fire = 1'b0;
        if (trig_wr) begin
            unique case (st_q)
                LT_IDLE:  st_d = (wdata == 8'h00) ? LT_ARMED : LT_IDLE;
                LT_ARMED: begin
                    st_d       = (wdata == 8'h00) ? LT_ARMED : LT_IDLE;
                    latch_fire = (wdata == 8'h01);
                end
                default:  st_d = LT_IDLE;
            endcase
        end
    end

    AST_FIRE_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        latch_fire |-> (st_q == LT_ARMED && trig_wr)); // R7
    AST_DISARM_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_wr && wdata != 8'h00) |=> (st_q == LT_IDLE)); // R8

endmodule

// File: rtl/rtcmap_clock.sv
module rtcmap_clock
    import rtcmap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       latch_fire,
    input  logic       reg_wr,
    input  logic [2:0] reg_idx,
    input  logic [7:0] wdata,
    output logic [7:0] reg_rdata
);
    rtc_time_t live, live_d, lat, lat_d;

    always_comb begin
        live_d = live;
        if (tick && !live.halt) begin
            if (live.sec >= SEC_TOP) begin
                live_d.sec = '0;
                if (live.min >= MIN_TOP) begin
                    live_d.min = '0;
                    if (live.hr >= HR_TOP) begin
                        live_d.hr = '0;
                        if (live.day == DAY_TOP) begin
                            live_d.day   = '0;
                            live_d.carry = 1'b1;
                        end else begin
                            live_d.day = live.day + 9'd1;
                        end
                    end else begin
                        live_d.hr = live.hr + 5'd1;
                    end
                end else begin
                    live_d.min = live.min + 6'd1;
                end
            end else begin
                live_d.sec = live.sec + 6'd1;
            end
        end

        lat_d = latch_fire ? live : lat;

        if (reg_wr) begin
            live_d = live;
            unique case (reg_idx)
                3'd0: begin live_d.sec = wdata[5:0]; lat_d.sec = wdata[5:0]; end
                3'd1: begin live_d.min = wdata[5:0]; lat_d.min = wdata[5:0]; end
                3'd2: begin live_d.hr  = wdata[4:0]; lat_d.hr  = wdata[4:0]; end
                3'd3: begin live_d.day[7:0] = wdata; lat_d.day[7:0] = wdata; end
                3'd4: begin
                    live_d.day[8] = wdata[0];
                    live_d.halt   = wdata[6];
                    live_d.carry  = wdata[7];
                    lat_d.day[8]  = wdata[0];
                    lat_d.halt    = wdata[6];
                    lat_d.carry   = wdata[7];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live <= '0;
            lat  <= '0;
        end else begin
            live <= live_d;
            lat  <= lat_d;
        end
    end

    always_comb begin
        unique case (reg_idx)
            3'd0:    reg_rdata = {2'b00, lat.sec};
            3'd1:    reg_rdata = {2'b00, lat.min};
            3'd2:    reg_rdata = {3'b000, lat.hr};
            3'd3:    reg_rdata = lat.day[7:0];
            3'd4:    reg_rdata = {lat.carry, lat.halt, 5'b00000, lat.day[8]};
            default: reg_rdata = 8'h00;
        endcase
    end

    AST_LATCH_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        latch_fire |=> (lat == $past(live))); // R7
    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (live.halt && !reg_wr) |=> (live == $past(live))); // R9
    AST_CARRY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (live.carry && !(reg_wr && reg_idx == 3'd4)) |=> live.carry); // R10
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && tick && reg_idx == 3'd0) |=> (live.sec == $past(wdata[5:0]))); // R12

endmodule

// File: rtl/rtc_bank_mapper.sv
module rtc_bank_mapper
    import rtcmap_pkg::*;
#(
    parameter int ROM_BANK_W = 7,
    parameter int RAM_BANK_W = 2,
    localparam int ROM_ADDR_W = ROM_BANK_W + 14,
    localparam int RAM_ADDR_W = RAM_BANK_W + 13
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick_1hz,
    input  logic                  cpu_wr,
    input  logic [15:0]           cpu_addr,
    input  logic [7:0]            cpu_wdata,
    output logic                  rom_cs,
    output logic [ROM_ADDR_W-1:0] rom_addr,
    output logic                  ram_cs,
    output logic [RAM_ADDR_W-1:0] ram_addr,
    output logic [7:0]            map_rdata
);
    localparam logic [7:0] SEL_RAM_MAX = 8'((1 << RAM_BANK_W) - 1);

    logic                  win_en;
    logic [ROM_BANK_W-1:0] rom_bank;
    logic [7:0]            sel;
    logic                  latch_fire;
    logic                  in_win, sel_ram, sel_rtc, rtc_wr;
    logic [7:0]            rtc_rdata;

    rtcmap_ctrl #(.ROM_BANK_W(ROM_BANK_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (cpu_wr),
        .region     (cpu_addr[15:13]),
        .wdata      (cpu_wdata),
        .win_en     (win_en),
        .rom_bank   (rom_bank),
        .sel        (sel),
        .latch_fire (latch_fire)
    );

    assign in_win  = (cpu_addr[15:13] == 3'b101);
    assign sel_ram = (sel <= SEL_RAM_MAX);
    assign sel_rtc = (sel >= SEL_RTC_LO) && (sel <= SEL_RTC_HI);
    assign rtc_wr  = cpu_wr && in_win && win_en && sel_rtc;

    rtcmap_clock u_clock (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick_1hz),
        .latch_fire (latch_fire),
        .reg_wr     (rtc_wr),
        .reg_idx    (sel[2:0]),
        .wdata      (cpu_wdata),
        .reg_rdata  (rtc_rdata)
    );

    assign rom_cs   = !cpu_addr[15];
    assign rom_addr = cpu_addr[14] ? {rom_bank, cpu_addr[13:0]}
                                   : {{ROM_BANK_W{1'b0}}, cpu_addr[13:0]};
    assign ram_cs   = in_win && win_en && sel_ram;
    assign ram_addr = {sel[RAM_BANK_W-1:0], cpu_addr[12:0]};
    assign map_rdata = (in_win && win_en && sel_rtc) ? rtc_rdata : 8'hFF;

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (in_win && !win_en) |-> (map_rdata == 8'hFF && !ram_cs)); // R2
    AST_BANK_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:14] == 2'b01) |-> (rom_addr[ROM_ADDR_W-1:14] != '0)); // R3
    AST_RTC_NO_RAM: assert property (@(posedge clk) disable iff (!rst_n)
        sel_rtc |-> !ram_cs); // R5

endmodule

// File: tb/tb_rtc_bank_mapper.sv
module tb_rtc_bank_mapper;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_1hz = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_wdata = 8'h00;
    logic        rom_cs, ram_cs;
    logic [20:0] rom_addr;
    logic [14:0] ram_addr;
    logic [7:0]  map_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int          q_kind[$];
    logic [31:0] q_exp[$];
    string       q_tag[$];

    always #5 clk = ~clk;

    rtc_bank_mapper dut (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .cpu_wr(cpu_wr),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .rom_cs(rom_cs),
        .rom_addr(rom_addr), .ram_cs(ram_cs), .ram_addr(ram_addr),
        .map_rdata(map_rdata)
    );

    // kinds: 0 rdata, 1 rom_addr, 2 ram_addr, 3 ram_cs, 4 rom_cs
    task automatic expect_at(input logic [15:0] a, input int kind,
                             input logic [31:0] exp, input string tag);
        @(negedge clk);
        cpu_wr   = 1'b0;
        cpu_addr = a;
        q_kind.push_back(kind);
        q_exp.push_back(exp);
        q_tag.push_back(tag);
    endtask

    task automatic bus_wr(input logic [15:0] a, input logic [7:0] d, input bit with_tick);
        @(negedge clk);
        cpu_addr  = a;
        cpu_wdata = d;
        cpu_wr    = 1'b1;
        tick_1hz  = with_tick;
        @(posedge clk);
        #1 cpu_wr = 1'b0;
        tick_1hz  = 1'b0;
    endtask

    task automatic do_tick();
        @(negedge clk);
        tick_1hz = 1'b1;
        @(posedge clk);
        #1 tick_1hz = 1'b0;
    endtask

    task automatic snap();
        bus_wr(16'h6000, 8'h00, 0);
        bus_wr(16'h6000, 8'h01, 0);
    endtask

    task automatic rtc_rd(input logic [7:0] idx, input logic [7:0] exp, input string tag);
        bus_wr(16'h4000, idx, 0);
        expect_at(16'hA000, 0, {24'h0, exp}, tag);
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            #3;
            while (q_kind.size() > 0) begin
                automatic int          k = q_kind.pop_front();
                automatic logic [31:0] e = q_exp.pop_front();
                automatic string       t = q_tag.pop_front();
                automatic logic [31:0] act;
                case (k)
                    0: act = {24'h0, map_rdata};
                    1: act = {11'h0, rom_addr};
                    2: act = {17'h0, ram_addr};
                    3: act = {31'h0, ram_cs};
                    default: act = {31'h0, rom_cs};
                endcase
                checks++;
                if (act !== e) begin
                    fails++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h", t, k, act, e);
                end
            end
        end
    end

    initial begin : watchdog
        #2000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        expect_at(16'hA000, 0, 32'hFF, "R1 window disabled");
        expect_at(16'h4123, 1, 32'h04123, "R1 bank one");
        expect_at(16'h4000, 3, 32'h0, "R1 no ram_cs");
        // R3 bank loading
        bus_wr(16'h2000, 8'hC5, 0);
        expect_at(16'h7FFF, 1, 32'h117FFF, "R3 bank 0x45");
        expect_at(16'h7FFF, 4, 32'h1, "R3 rom_cs");
        expect_at(16'h1234, 1, 32'h001234, "R3 fixed bank");
        expect_at(16'hA000, 4, 32'h0, "R3 rom_cs low");
        bus_wr(16'h3FFF, 8'h80, 0);
        expect_at(16'h4000, 1, 32'h04000, "R3 zero to one");
        // R4 RAM banks
        bus_wr(16'h0000, 8'h0A, 0);
        bus_wr(16'h4000, 8'h02, 0);
        expect_at(16'hA123, 3, 32'h1, "R4 ram_cs");
        expect_at(16'hA123, 2, 32'h4123, "R4 ram_addr bank2");
        bus_wr(16'h5FFF, 8'h03, 0);
        expect_at(16'hA000, 2, 32'h6000, "R4 ram_addr bank3");
        expect_at(16'hA000, 0, 32'hFF, "R4 rdata idle");
        // R2 disable on other value
        bus_wr(16'h1FFF, 8'h1A, 0);
        expect_at(16'hA000, 3, 32'h0, "R2 disabled cs");
        expect_at(16'hA000, 0, 32'hFF, "R2 disabled rdata");
        // R11 / R6 clock writes
        bus_wr(16'h0000, 8'h0A, 0);
        bus_wr(16'h4000, 8'h08, 0);
        expect_at(16'hA000, 3, 32'h0, "R5 rtc no ram_cs");
        bus_wr(16'hA000, 8'h3A, 0);
        expect_at(16'hA000, 0, 32'h3A, "R11 seconds");
        bus_wr(16'h4000, 8'h09, 0);
        bus_wr(16'hA000, 8'h3B, 0);
        bus_wr(16'h4000, 8'h0A, 0);
        bus_wr(16'hA000, 8'hD7, 0);
        expect_at(16'hA000, 0, 32'h17, "R11 hours masked");
        bus_wr(16'h4000, 8'h0B, 0);
        bus_wr(16'hA000, 8'hFF, 0);
        bus_wr(16'h4000, 8'h0C, 0);
        bus_wr(16'hA000, 8'hFF, 0);
        expect_at(16'hA000, 0, 32'hC1, "R6 reg 0C bits");
        bus_wr(16'hA000, 8'h01, 0);
        expect_at(16'hA000, 0, 32'h01, "R6 day bit8");
        // R9 / R10 cascade
        do_tick();
        rtc_rd(8'h08, 8'h3A, "R7 latched unchanged by tick");
        do_tick();
        snap();
        rtc_rd(8'h08, 8'h00, "R10 sec wrap");
        rtc_rd(8'h09, 8'h00, "R9 min wrap");
        rtc_rd(8'h0A, 8'h00, "R9 hour wrap");
        rtc_rd(8'h0B, 8'h00, "R10 day low");
        rtc_rd(8'h0C, 8'h80, "R10 carry set");
        // R8 disarm
        do_tick();
        bus_wr(16'h6000, 8'h00, 0);
        bus_wr(16'h7000, 8'h05, 0);
        bus_wr(16'h6000, 8'h01, 0);
        rtc_rd(8'h08, 8'h00, "R8 disarmed");
        snap();
        rtc_rd(8'h08, 8'h01, "R7 snapshot");
        rtc_rd(8'h0C, 8'h80, "R10 carry sticky");
        // halt and carry clear
        bus_wr(16'hA000, 8'h40, 0);
        expect_at(16'hA000, 0, 32'h40, "R10 carry cleared");
        do_tick();
        do_tick();
        snap();
        rtc_rd(8'h08, 8'h01, "R9 halted");
        // R12 collision
        bus_wr(16'h4000, 8'h0C, 0);
        bus_wr(16'hA000, 8'h00, 0);
        bus_wr(16'h4000, 8'h08, 0);
        bus_wr(16'hA000, 8'h10, 1);
        snap();
        rtc_rd(8'h08, 8'h10, "R12 write wins");
        do_tick();
        snap();
        rtc_rd(8'h08, 8'h11, "R9 running");
        // R5 unmapped selector
        bus_wr(16'h4000, 8'h05, 0);
        expect_at(16'hA000, 0, 32'hFF, "R5 unmapped rdata");
        expect_at(16'hA000, 3, 32'h0, "R5 unmapped cs");
        // R2 writes ignored while disabled
        bus_wr(16'h4000, 8'h08, 0);
        bus_wr(16'h0000, 8'h00, 0);
        bus_wr(16'hA000, 8'h22, 0);
        expect_at(16'hA000, 0, 32'hFF, "R2 read disabled");
        bus_wr(16'h0000, 8'h0A, 0);
        snap();
        expect_at(16'hA000, 0, 32'h11, "R2 write ignored");
        repeat (3) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule